// File: doc/BRIEF.md
# H-Bridge Direction and Dead-Time Controller

This block drives the four gate enables of a full bridge from two direction request lines and one PWM line. Each of the two legs has a high-side enable and a low-side enable. For a valid direction the controller picks one diagonal. It holds the high-side switch of that diagonal on and gates the PWM signal onto the low-side switch of the opposite leg. When the two request lines are equal, the bridge is idle and all four enables stay low.

Every change of the decoded command forces all four enables low for a programmable number of clock cycles. Only after that interval may the new diagonal turn on. This covers start, stop and reversal alike. If the command moves again while the interval is running, the interval starts over. The direction lines pass through a two-flop synchronizer, so they may be driven from another clock domain. Each gate enable comes straight from a register.

Top module: `hbridge_deadtime_ctrl`

## Requirements
- R1: With fwdCmd=1 and revCmd=0 (forward), once settled, hiLeg0 is continuously 1, loLeg1 follows pwmIn, and hiLeg1 and loLeg0 are 0.
- R2: With fwdCmd=0 and revCmd=1 (reverse), once settled, hiLeg1 is continuously 1, loLeg0 follows pwmIn, and hiLeg0 and loLeg1 are 0.
- R3: When fwdCmd equals revCmd (both 0 or both 1), all four enables are 0 whatever pwmIn does.
- R4: After a change of the decoded command, with DEAD_CYCLES=D and two synchronizer stages, the old enables still show after the 3rd rising edge and are all 0 from the 4th rising edge. The enables of the new direction appear on the (D+4)th rising edge and not earlier.
- R5: hiLeg0 and loLeg0 are never 1 together, and hiLeg1 and loLeg1 are never 1 together.
- R6: A high-side enable rises only after both low-side enables have been 0 for at least D consecutive cycles.
- R7: A further command change during the dead interval restarts it. The final direction appears on the (D+4)th rising edge after the last change, and the abandoned direction never drives the bridge.
- R8: While rstN is low and right after reset, all four enables are 0 and the controller is idle.
- R9: In a driving state, the low-side enable takes the value pwmIn had at the previous rising edge, so it lags pwmIn by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fwdCmd | input | 1 | Forward request, may be asynchronous |
| revCmd | input | 1 | Reverse request, may be asynchronous |
| pwmIn | input | 1 | PWM stream, synchronous to clk |
| hiLeg0 | output | 1 | High-side enable of leg 0 |
| loLeg0 | output | 1 | Low-side enable of leg 0 |
| hiLeg1 | output | 1 | High-side enable of leg 1 |
| loLeg1 | output | 1 | Low-side enable of leg 1 |

## Verification
The assertions assume that pwmIn is synchronous to clk, because it feeds the gate registers directly. They also assume that reset is held low for at least a couple of edges, so the synchronizer holds known values before the checks are enabled. The direction lines may change at any time. The bench still changes them only on falling edges and keeps each level for whole cycles, so the expected edge counts in R4 and R7 are exact. It also changes pwmIn only on falling edges, which keeps that line inside the synchronous assumption.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

  typedef enum logic [1:0] {
    CMD_OFF = 2'd0,
    CMD_FWD = 2'd1,
    CMD_REV = 2'd2
  } dirCmd_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_DEAD = 2'd1,
    ST_FWD  = 2'd2,
    ST_REV  = 2'd3
  } ctlState_t;

  // Strobes from control to datapath: which diagonal may conduct.
  typedef struct packed {
    logic driveFwd;
    logic driveRev;
  } gateStrobe_t;

  // Equal request lines mean idle.
  function automatic dirCmd_t decodeDir(logic fwd, logic rev);
    case ({fwd, rev})
      2'b10:   return CMD_FWD;
      2'b01:   return CMD_REV;
      default: return CMD_OFF;
    endcase
  endfunction

endpackage

// File: rtl/hbridge_datapath.sv
module hbridge_datapath
  import hbridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEAD_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fwdCmd,
  input  logic        revCmd,
  input  logic        pwmIn,
  input  gateStrobe_t strobe,
  output dirCmd_t     dirCmd,
  output logic        hiLeg0,
  output logic        loLeg0,
  output logic        hiLeg1,
  output logic        loLeg1
);

  localparam int GAP_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(DEAD_CYCLES);

  logic [SYNC_STAGES-1:0] fwdSync;
  logic [SYNC_STAGES-1:0] revSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdSync <= '0;
      revSync <= '0;
    end else begin
      fwdSync <= {fwdSync[SYNC_STAGES-2:0], fwdCmd};
      revSync <= {revSync[SYNC_STAGES-2:0], revCmd};
    end
  end

  assign dirCmd = decodeDir(fwdSync[SYNC_STAGES-1], revSync[SYNC_STAGES-1]);

  // Gate registers: high side held, low side of opposite leg chopped by PWM.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLeg0 <= 1'b0;
      loLeg0 <= 1'b0;
      hiLeg1 <= 1'b0;
      loLeg1 <= 1'b0;
    end else begin
      hiLeg0 <= strobe.driveFwd;
      loLeg1 <= strobe.driveFwd & pwmIn;
      hiLeg1 <= strobe.driveRev;
      loLeg0 <= strobe.driveRev & pwmIn;
    end
  end

  // Checker state: cycles since either low side was last seen on.
  logic [GAP_W-1:0] quietCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                 quietCnt <= GAP_MIN;
    else if (loLeg0 | loLeg1)  quietCnt <= '0;
    else if (quietCnt < GAP_MIN) quietCnt <= quietCnt + 1'b1;
  end

  p_leg0_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(hiLeg0 && loLeg0));

  p_leg1_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(hiLeg1 && loLeg1));

  p_hi_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hiLeg0) || $rose(hiLeg1)) |-> (quietCnt >= GAP_MIN));

  p_idle_gates_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.driveFwd && !strobe.driveRev) |=> !(hiLeg0 || loLeg0 || hiLeg1 || loLeg1));

endmodule

// File: rtl/hbridge_control.sv
module hbridge_control
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  dirCmd_t     dirCmd,
  output gateStrobe_t strobe
);

  localparam int CNT_W = $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEAD_CYCLES - 1);

  ctlState_t      state;
  dirCmd_t        curCmd;
  logic [CNT_W-1:0] deadCnt;

  function automatic ctlState_t targetOf(dirCmd_t c);
    case (c)
      CMD_FWD: return ST_FWD;
      CMD_REV: return ST_REV;
      default: return ST_OFF;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OFF;
      curCmd  <= CMD_OFF;
      deadCnt <= '0;
    end else if (dirCmd != curCmd) begin
      // Any new command (also mid-interval) restarts the all-off window.
      curCmd  <= dirCmd;
      state   <= ST_DEAD;
      deadCnt <= '0;
    end else if (state == ST_DEAD) begin
      if (deadCnt == CNT_LAST) state   <= targetOf(curCmd);
      else                     deadCnt <= deadCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.driveFwd = (state == ST_FWD);
    strobe.driveRev = (state == ST_REV);
  end

  p_change_enters_dead_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dirCmd != curCmd) |=> (state == ST_DEAD && deadCnt == '0));

  p_fwd_after_full_dead_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_FWD) |-> ($past(state) == ST_DEAD && $past(deadCnt) == CNT_LAST));

  p_rev_after_full_dead_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_REV) |-> ($past(state) == ST_DEAD && $past(deadCnt) == CNT_LAST));

endmodule

// File: rtl/hbridge_deadtime_ctrl.sv
module hbridge_deadtime_ctrl #(
  parameter int DEAD_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic fwdCmd,
  input  logic revCmd,
  input  logic pwmIn,
  output logic hiLeg0,
  output logic loLeg0,
  output logic hiLeg1,
  output logic loLeg1
);
  import hbridge_pkg::*;

  dirCmd_t     dirCmd;
  gateStrobe_t strobe;

  hbridge_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEAD_CYCLES(DEAD_CYCLES)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .fwdCmd(fwdCmd), .revCmd(revCmd), .pwmIn(pwmIn),
    .strobe(strobe), .dirCmd(dirCmd),
    .hiLeg0(hiLeg0), .loLeg0(loLeg0), .hiLeg1(hiLeg1), .loLeg1(loLeg1)
  );

  hbridge_control #(
    .DEAD_CYCLES(DEAD_CYCLES)
  ) uControl (
    .clk(clk), .rstN(rstN), .dirCmd(dirCmd), .strobe(strobe)
  );

  // R8: reset leaves the bridge dark on the first active cycle.
  p_reset_dark_r8: assert property (@(posedge clk)
    $rose(rstN) |-> !(hiLeg0 || loLeg0 || hiLeg1 || loLeg1));

endmodule

// File: tb/hbridge_deadtime_ctrl_test.sv
module hbridge_deadtime_ctrl_test;

  localparam int PERIOD = 10;
  localparam int DEAD   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fwdCmd = 1'b0;
  logic revCmd = 1'b0;
  logic pwmIn = 1'b0;
  logic hiLeg0, loLeg0, hiLeg1, loLeg1;

  int checks = 0;
  int fails = 0;
  int monViol = 0;

  always #(PERIOD/2) clk = ~clk;

  hbridge_deadtime_ctrl #(.DEAD_CYCLES(DEAD)) uut (
    .clk(clk), .rstN(rstN), .fwdCmd(fwdCmd), .revCmd(revCmd), .pwmIn(pwmIn),
    .hiLeg0(hiLeg0), .loLeg0(loLeg0), .hiLeg1(hiLeg1), .loLeg1(loLeg1)
  );

  // Per-cycle monitor: leg exclusivity (R5) and high-side gap (R6).
  int  quiet = 1000;
  logic prevHi0 = 1'b0, prevHi1 = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if ((hiLeg0 && loLeg0) || (hiLeg1 && loLeg1)) begin
        monViol++;
        $display("FAIL R5 leg overlap: got %b%b%b%b expected no leg with both on",
                 hiLeg0, loLeg0, hiLeg1, loLeg1);
      end
      if (((hiLeg0 && !prevHi0) || (hiLeg1 && !prevHi1)) && quiet < DEAD) begin
        monViol++;
        $display("FAIL R6 high side rose after %0d quiet cycles, expected >= %0d", quiet, DEAD);
      end
      if (loLeg0 || loLeg1) quiet = 0;
      else if (quiet < 1000) quiet++;
      prevHi0 = hiLeg0;
      prevHi1 = hiLeg1;
    end
  end

  task automatic checkGates(string req, logic [3:0] exp);
    logic [3:0] got;
    got = {hiLeg0, loLeg0, hiLeg1, loLeg1};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: gates {hi0,lo0,hi1,lo1} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic setDir(logic f, logic r);
    @(negedge clk);
    fwdCmd = f;
    revCmd = r;
  endtask

  task automatic setPwm(logic p);
    @(negedge clk);
    pwmIn = p;
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    checkGates("R8 in reset", 4'b0000);
    @(negedge clk);
    rstN = 1'b1;
    waitEdges(3);
    checkGates("R8 after reset", 4'b0000);
  endtask

  task automatic testForward();
    setPwm(1'b1);
    setDir(1'b1, 1'b0);
    waitEdges(DEAD + 3);
    checkGates("R4 forward not before D+4 edges", 4'b0000);
    waitEdges(1);
    checkGates("R1 forward on pwm high", 4'b1001);
    setPwm(1'b0);
    waitEdges(1);
    checkGates("R9 forward low side follows pwm low", 4'b1000);
    setPwm(1'b1);
    waitEdges(1);
    checkGates("R9 forward low side follows pwm high", 4'b1001);
  endtask

  task automatic testReversal();
    setDir(1'b0, 1'b1);
    waitEdges(3);
    checkGates("R4 old direction held through 3rd edge", 4'b1001);
    waitEdges(1);
    checkGates("R4 all off from 4th edge", 4'b0000);
    waitEdges(DEAD - 1);
    checkGates("R4 still off at edge D+3", 4'b0000);
    waitEdges(1);
    checkGates("R2 reverse on pwm high", 4'b0110);
    setPwm(1'b0);
    waitEdges(1);
    checkGates("R2 reverse low side off with pwm low", 4'b0010);
  endtask

  task automatic testBothHigh();
    setDir(1'b1, 1'b1);
    waitEdges(4);
    checkGates("R3 both high turns off", 4'b0000);
    for (int i = 0; i < 6; i++) begin
      setPwm(i[0]);
      waitEdges(DEAD / 2);
      checkGates("R3 both high ignores pwm", 4'b0000);
    end
  endtask

  task automatic testBothLow();
    setPwm(1'b1);
    setDir(1'b1, 1'b0);
    waitEdges(DEAD + 4);
    checkGates("R1 forward from idle", 4'b1001);
    setDir(1'b0, 1'b0);
    waitEdges(4);
    checkGates("R3 both low turns off", 4'b0000);
    waitEdges(DEAD + 8);
    checkGates("R3 both low stays off with pwm high", 4'b0000);
  endtask

  task automatic testRestart();
    setDir(1'b1, 1'b0);
    waitEdges(10);
    checkGates("R7 mid interval still off", 4'b0000);
    setDir(1'b0, 1'b1);
    waitEdges(DEAD + 3);
    checkGates("R7 abandoned forward never driven, restart holds off", 4'b0000);
    waitEdges(1);
    checkGates("R7 reverse after restarted interval", 4'b0110);
  endtask

  initial begin
    waitEdges(4);
    testReset();
    testForward();
    testReversal();
    testBothHigh();
    testBothLow();
    testRestart();
    setDir(1'b0, 1'b0);
    waitEdges(DEAD + 6);
    checks++;
    if (monViol != 0) begin
      fails++;
      $display("FAIL R5/R6 monitor: got %0d violations expected 0", monViol);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule